// File: doc/BRIEF.md
# Dual-Channel Byte-Split Double-Buffered Word Loader

This block takes 12-bit words for two channels from a narrow 8-bit bus. Each channel has two staging registers: an 8-bit low part and a 4-bit high part. A 2-bit address picks the staging register to write. The low address bit picks the low or high part. The high address bit picks the channel. A write happens when the strobe and select lines are both low.

A separate active-low update line copies the staging registers of both channels into the output registers in the same cycle. This lets the two outputs change together. There is also a pass-through mode. When update, select and strobe are all low, the write reaches the staging register and the output word on the same clock edge. In that mode both output words take the new staging contents. An asynchronous active-low clear sets every register to zero at once.

All control inputs are sampled on the rising edge of the system clock. Only the clear acts without the clock.

Top module: `dual_byte_loader`

## Requirements
- R1: A write to address 0 (address 2'b00) loads channel A's low staging part from bus bits 7..0, with bus bit 0 as word bit 0.
- R2: A write to address 1 (2'b01) loads channel A's high staging part from bus bits 3..0. Bus bit 3 becomes word bit 11, and bus bits 7..4 have no effect.
- R3: Addresses 2 (2'b10) and 3 (2'b11) load channel B's low and high staging parts, with the same bit mapping as channel A.
- R4: With clear high, update high, select low and strobe low, only the addressed staging register changes. Both output words keep their values.
- R5: With clear high, update low, select high and strobe low, both output words take their channel's staging contents on the same clock edge.
- R6: With update, select and strobe all low, the addressed staging register loads. On that same edge both output words become equal to the updated staging contents.
- R7: Clear low sets all staging and output registers to zero at once, without waiting for a clock edge, whatever the other inputs are.
- R8: With strobe high, or with select and update both high, no register changes.
- R9: Each output word is {high part, low part}: the high part sits in word bits 11..8 and the low part in bits 7..0. Channel A is `dacWord[11:0]` and channel B is `dacWord[23:12]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs except clear are sampled on its rising edge |
| clrN | input | 1 | Asynchronous clear, active low |
| updN | input | 1 | Transfer staging to output, active low |
| csN | input | 1 | Select, active low |
| wrN | input | 1 | Write strobe, active low |
| addr | input | 2 | Staging register address: bit 1 selects the channel, bit 0 selects the high part |
| dataIn | input | 8 | Parallel data bus |
| dacWord | output | 24 | Output words: channel B in bits 23..12, channel A in bits 11..0 |

## Verification
For each channel, the bench sweeps a grid of low-byte values against all 16 high-nibble values. The unused upper bus bits are set to the inverse of the nibble, so a wrong bit mapping, a swapped channel or a leaking upper bit shows up in the word. The bench reads the outputs after the staging writes and before the update. This separates staging from transfer. A pass-through write that leaves the other channel's staging contents pending shows whether transparency covers both channels. Clear is pulsed between clock edges to show that it acts without the clock. Idle combinations (strobe high, or select and update both high) are followed by an update, so any disturbance to a staging register becomes visible at the outputs.

// File: rtl/dbl_loader_pkg.sv
package dbl_loader_pkg;
  localparam int CH_COUNT   = 2;
  localparam int SLOT_COUNT = 2 * CH_COUNT;

  typedef struct packed {
    logic [SLOT_COUNT-1:0] loadSel;  // one-hot staging register write
    logic                  xfer;     // copy staging into outputs
  } strobe_t;
endpackage

// File: rtl/dbl_loader_ctrl.sv
module dbl_loader_ctrl
  import dbl_loader_pkg::*;
#(
  parameter int ADDR_W = $clog2(SLOT_COUNT)
) (
  input  logic              updN,
  input  logic              csN,
  input  logic              wrN,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           strobe
);
  logic writeHit;

  assign writeHit = !wrN && !csN;

  always_comb begin
    strobe = '0;
    for (int s = 0; s < SLOT_COUNT; s++) begin
      strobe.loadSel[s] = writeHit && (int'(addr) == s);
    end
    strobe.xfer = !wrN && !updN;
  end
endmodule

// File: rtl/dbl_loader_datapath.sv
module dbl_loader_datapath
  import dbl_loader_pkg::*;
#(
  parameter int BUS_W = 8,
  parameter int CH_W  = 12,
  parameter int LO_W  = 8
) (
  input  logic                     clk,
  input  logic                     clrN,
  input  strobe_t                  strobe,
  input  logic [BUS_W-1:0]         dataIn,
  output logic [CH_COUNT*CH_W-1:0] stageWord,
  output logic [CH_COUNT*CH_W-1:0] outWord
);
  localparam int HI_W = CH_W - LO_W;

  for (genvar ch = 0; ch < CH_COUNT; ch++) begin : g_chan
    logic [LO_W-1:0] loReg, loNext;
    logic [HI_W-1:0] hiReg, hiNext;
    logic [CH_W-1:0] outReg;

    assign loNext = strobe.loadSel[2*ch]   ? dataIn[LO_W-1:0] : loReg;
    assign hiNext = strobe.loadSel[2*ch+1] ? dataIn[HI_W-1:0] : hiReg;

    always_ff @(posedge clk or negedge clrN) begin
      if (!clrN) begin
        loReg  <= '0;
        hiReg  <= '0;
        outReg <= '0;
      end else begin
        loReg <= loNext;
        hiReg <= hiNext;
        if (strobe.xfer) outReg <= {hiNext, loNext};
      end
    end

    assign stageWord[ch*CH_W +: CH_W] = {hiReg, loReg};
    assign outWord[ch*CH_W +: CH_W]   = outReg;
  end
endmodule

// File: rtl/dual_byte_loader.sv
module dual_byte_loader
  import dbl_loader_pkg::*;
#(
  parameter int BUS_W = 8,
  parameter int CH_W  = 12,
  parameter int LO_W  = 8,
  localparam int ADDR_W = $clog2(SLOT_COUNT)
) (
  input  logic                     clk,
  input  logic                     clrN,
  input  logic                     updN,
  input  logic                     csN,
  input  logic                     wrN,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [BUS_W-1:0]         dataIn,
  output logic [CH_COUNT*CH_W-1:0] dacWord
);
  strobe_t                  strobe;
  logic [CH_COUNT*CH_W-1:0] stageWord;

  dbl_loader_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .updN(updN), .csN(csN), .wrN(wrN), .addr(addr), .strobe(strobe)
  );

  dbl_loader_datapath #(.BUS_W(BUS_W), .CH_W(CH_W), .LO_W(LO_W)) u_dp (
    .clk(clk), .clrN(clrN), .strobe(strobe), .dataIn(dataIn),
    .stageWord(stageWord), .outWord(dacWord)
  );
endmodule

// File: rtl/dual_byte_loader_chk.sv
module dual_byte_loader_chk #(
  parameter int BUS_W  = 8,
  parameter int CH_W   = 12,
  parameter int LO_W   = 8,
  parameter int ADDR_W = 2,
  parameter int WORD_W = 24
) (
  input logic              clk,
  input logic              clrN,
  input logic              updN,
  input logic              csN,
  input logic              wrN,
  input logic [ADDR_W-1:0] addr,
  input logic [BUS_W-1:0]  dataIn,
  input logic [WORD_W-1:0] dacWord,
  input logic [WORD_W-1:0] stageWord
);
  localparam int HI_W = CH_W - LO_W;

  // R7: while clear is low the outputs read zero
  always_ff @(posedge clk) begin
    if (!clrN) p_clear_zero_r7: assert (dacWord == '0);
  end

  // R8: idle combinations leave outputs and staging alone
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!clrN)
    (wrN || (csN && updN)) |=> ($stable(dacWord) && $stable(stageWord)));

  // R4: a staging write without update keeps the outputs
  p_load_hold_r4: assert property (@(posedge clk) disable iff (!clrN)
    (!wrN && !csN && updN) |=> $stable(dacWord));

  // R5: update copies the staging contents seen before the edge
  p_update_copy_r5: assert property (@(posedge clk) disable iff (!clrN)
    (!wrN && !updN && csN) |=> (dacWord == $past(stageWord)));

  // R6: pass-through makes the outputs equal the new staging contents
  p_transp_r6: assert property (@(posedge clk) disable iff (!clrN)
    (!wrN && !updN && !csN) |=> (dacWord == stageWord));

  // R2: high part of channel A takes only the low bus bits
  p_hinib_r2: assert property (@(posedge clk) disable iff (!clrN)
    (!wrN && !csN && addr == ADDR_W'(1)) |=>
      (stageWord[CH_W-1:LO_W] == $past(dataIn[HI_W-1:0])));
endmodule

bind dual_byte_loader dual_byte_loader_chk #(
  .BUS_W(BUS_W), .CH_W(CH_W), .LO_W(LO_W), .ADDR_W(ADDR_W),
  .WORD_W(dbl_loader_pkg::CH_COUNT*CH_W)
) u_chk (
  .clk(clk), .clrN(clrN), .updN(updN), .csN(csN), .wrN(wrN),
  .addr(addr), .dataIn(dataIn), .dacWord(dacWord), .stageWord(stageWord)
);

// File: tb/sim_dual_byte_loader.sv
`timescale 1ns/1ps
module sim_dual_byte_loader;
  logic        clk = 1'b0;
  logic        clrN = 1'b0;
  logic        updN = 1'b1;
  logic        csN = 1'b1;
  logic        wrN = 1'b1;
  logic [1:0]  addr = '0;
  logic [7:0]  dataIn = '0;
  logic [23:0] dacWord;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // bench model: staging and output words per channel
  logic [11:0] expStage [2];
  logic [11:0] expOut [2];

  always #2.5 clk = ~clk;

  dual_byte_loader u0 (
    .clk(clk), .clrN(clrN), .updN(updN), .csN(csN), .wrN(wrN),
    .addr(addr), .dataIn(dataIn), .dacWord(dacWord)
  );

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] modelOut();
    return {expOut[1], expOut[0]};
  endfunction

  // one bus cycle with given control levels; model applied at the edge
  task automatic cycle(input logic u, input logic c, input logic w,
                       input logic [1:0] a, input logic [7:0] d);
    updN = u; csN = c; wrN = w; addr = a; dataIn = d;
    @(posedge clk);
    if (!w && !c) begin
      if (a[0]) expStage[a[1]][11:8] = d[3:0];
      else      expStage[a[1]][7:0]  = d;
    end
    if (!w && !u) begin
      expOut[0] = expStage[0];
      expOut[1] = expStage[1];
    end
    @(negedge clk);
    updN = 1'b1; csN = 1'b1; wrN = 1'b1;
  endtask

  initial begin
    expStage[0] = '0; expStage[1] = '0;
    expOut[0] = '0;   expOut[1] = '0;
    repeat (3) @(negedge clk);
    // R7: reset state
    check("R7 reset state", dacWord, 24'h0);
    clrN = 1'b1;
    @(negedge clk);

    // R1 R2 R3 R4 R5 R9: sweep low bytes against every nibble per channel
    for (int ch = 0; ch < 2; ch++) begin
      for (int lo = 0; lo < 256; lo += 17) begin
        for (int hi = 0; hi < 16; hi++) begin
          logic [7:0] hiBus;
          hiBus = {~hi[3:0], hi[3:0]};
          cycle(1, 0, 0, 2'(ch*2), 8'(lo));
          cycle(1, 0, 0, 2'(ch*2+1), hiBus);
          check("R4 outputs held during staging", dacWord, modelOut());
          cycle(0, 1, 0, 2'b00, 8'h00);
          check(ch == 0 ? "R1 R2 R5 R9 channel A word" : "R3 R5 R9 channel B word",
                dacWord, modelOut());
        end
      end
    end

    // R6: pass-through on B while A has pending staging
    cycle(1, 0, 0, 2'b00, 8'h5A);
    cycle(1, 0, 0, 2'b01, 8'hF3);
    check("R4 A pending not visible", dacWord, modelOut());
    cycle(0, 0, 0, 2'b11, 8'h0C);
    check("R6 pass-through both channels", dacWord, {12'hC00 | {4'h0, expStage[1][7:0]}, 12'h35A});
    check("R6 pass-through model", dacWord, modelOut());
    cycle(0, 0, 0, 2'b10, 8'hE1);
    check("R6 pass-through low byte same edge", dacWord[23:12], 24'(12'hCE1));

    // R8: idle combinations
    cycle(1, 0, 0, 2'b00, 8'h11);   // stage A low = 11 (pending)
    cycle(0, 0, 1, 2'b01, 8'h0F);   // strobe high: nothing
    check("R8 strobe high no change", dacWord, modelOut());
    cycle(1, 1, 0, 2'b10, 8'h77);   // select and update high: nothing
    check("R8 select and update high no change", dacWord, modelOut());
    cycle(0, 1, 0, 2'b00, 8'h00);
    check("R8 staging untouched by idle cycles", dacWord, {12'hCE1, 12'h311});

    // R7: clear between edges, no clock needed
    @(posedge clk);
    #1 clrN = 1'b0;
    #0.5;
    check("R7 async clear immediate", dacWord, 24'h0);
    expStage[0] = '0; expStage[1] = '0; expOut[0] = '0; expOut[1] = '0;
    @(negedge clk);
    // R7: clear wins over a write and an update
    cycle(0, 0, 0, 2'b00, 8'hAB);
    expStage[0] = '0; expOut[0] = '0; expOut[1] = '0;
    check("R7 clear overrides write", dacWord, 24'h0);
    clrN = 1'b1;
    @(negedge clk);
    cycle(0, 1, 0, 2'b00, 8'h00);
    check("R7 staging cleared", dacWord, 24'h0);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule